// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block carries out the multi-word stack and block-transfer instructions of a small RISC core. The core has eight low registers, a stack pointer, a link register and a program counter. A decoder hands the block four things in one pulse: an operation kind, an 8-bit register list, an extra-register bit and a base register selector. With them comes the current value of the base. The block then runs one 32-bit memory transfer per cycle. Each stored word comes from the register-file read port, and each loaded word goes to the register-file write port. A load of the program counter goes out as a branch request instead.

Pushes walk the list from the highest register down. When the extra bit is set, the link register is placed on top. The stack pointer drops by four bytes per word, so the lowest register ends up at the lowest address. Pops, store-multiple and load-multiple walk the list from the lowest register up through ascending word addresses. A pop with the extra bit set loads the program counter last. When all words are moved, the updated base is written back in a single finishing cycle, and that same cycle raises `done`. Every transfer waits on a memory ready handshake.

Top module: `reglist_seq`

## Requirements
- R1: After reset the block is idle: `memReq`, `done`, `rfWe` and `branchEn` are all low.
- R2: Bit i of `regList` selects low register i. Register indices on `rfRdIdx` and `rfWrIdx` are 0 to 7 for the low registers, 13 for the stack pointer, 14 for the link register and 15 for the program counter.
- R3: A push (`opKind` 0) stores the link register first when `extraBit` is set, then the listed registers from highest to lowest. The addresses are base-4, base-8 and so on downward. The stack pointer (index 13) is then written with base minus 4 times the word count.
- R4: A pop (`opKind` 1) loads the listed registers from lowest to highest, at addresses base, base+4 and so on upward. The stack pointer is then written with base plus 4 times the word count.
- R5: A pop with `extraBit` set loads one more word after the list. That word is not written to the register file. It is presented as `branchEn` with `branchTarget` equal to the loaded word, and no memory request follows it.
- R6: Store-multiple (`opKind` 2) and load-multiple (`opKind` 3) use low register `baseSel` as base. They transfer from lowest to highest at ascending addresses starting at the base, and write base plus 4 times the count back to `baseSel`. `extraBit` is ignored for these kinds.
- R7: While `memReq` is high and `memReady` is low, address, register index and direction hold, and nothing is written. A transfer completes only in a cycle with `memReady` high.
- R8: An empty list with no extra word raises `done` in the cycle after `start`, with no memory request and no register write.
- R9: A load-multiple whose base register is also in the list keeps the loaded value: the finishing cycle writes nothing.
- R10: `done` is a one-cycle pulse in the cycle after the last completed transfer, and the base writeback happens in that same cycle. `start` is ignored while an instruction is in progress.
- R11: `memWe` is high for push and store-multiple transfers and low for pop and load-multiple transfers, and `memWdata` equals the register-file data of the register being stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Accept a decoded instruction when idle |
| opKind | input | 2 | 0 push, 1 pop, 2 store-multiple, 3 load-multiple |
| regList | input | 8 | Low-register selection mask |
| extraBit | input | 1 | Add link register (push) or program counter (pop) |
| baseSel | input | 3 | Base low register for store/load-multiple |
| baseValue | input | 32 | Current value of the base or stack pointer |
| done | output | 1 | Instruction finished (one-cycle pulse) |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | Transfer is a write |
| memAddr | output | 32 | Word address in bytes |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data |
| memReady | input | 1 | Transfer completes this cycle |
| rfRdIdx | output | 4 | Register-file read index |
| rfRdData | input | 32 | Register-file read data |
| rfWe | output | 1 | Register-file write enable |
| rfWrIdx | output | 4 | Register-file write index |
| rfWrData | output | 32 | Register-file write data |
| branchEn | output | 1 | Loaded program counter is taken |
| branchTarget | output | 32 | Branch destination |

## Verification
The embedded properties watch these behaviours on every cycle: a stalled request holding its address and register index, consecutive transfers stepping one word in the correct direction with strictly falling (push) or rising (other kinds) register indices, the program-counter load being the final transfer, the single-cycle `done` pulse, and an empty instruction finishing at once. The behavioural model in the bench compares the exact sequence of addresses, indices, stored data and loaded writes against lists built from the register mask. Only that comparison can show the final base values, the suppressed writeback when a load-multiple base is in its own list, the ignored extra bit of block transfers, and a second `start` arriving mid-instruction leaving the sequence untouched.

// File: rtl/reglist_seq_pkg.sv
`timescale 1ns/1ps
package reglist_seq_pkg;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_STM  = 2'd2,
    OP_LDM  = 2'd3
  } seqOp_e;

  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IDX_SP = 4'd13;
  localparam logic [IDX_W-1:0] IDX_LR = 4'd14;
  localparam logic [IDX_W-1:0] IDX_PC = 4'd15;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic xfer;
    logic finish;
  } seqStrobe_t;

endpackage

// File: rtl/reglist_seq_ctrl.sv
`timescale 1ns/1ps
module reglist_seq_ctrl
  import reglist_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       startHasWork,
  input  logic       memReady,
  input  logic       lastPending,
  output seqStrobe_t strb,
  output logic       done
);

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_FIN} seqState_e;

  seqState_e state, stateNxt;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    case (state)
      S_IDLE: begin
        if (start) begin
          strb.capture = 1'b1;
          stateNxt     = startHasWork ? S_XFER : S_FIN;
        end
      end
      S_XFER: begin
        strb.xfer = 1'b1;
        if (memReady && lastPending) stateNxt = S_FIN;
      end
      S_FIN: begin
        strb.finish = 1'b1;
        stateNxt    = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end

  assign done = strb.finish;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10

  AST_EMPTY_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && !startHasWork) |=> (done && !strb.xfer)); // R8

endmodule

// File: rtl/reglist_seq_dpath.sv
`timescale 1ns/1ps
module reglist_seq_dpath
  import reglist_seq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LIST_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [1:0]        opKind,
  input  logic [LIST_W-1:0] regList,
  input  logic              extraBit,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [WORD_W-1:0] baseValue,
  input  logic              memReady,
  input  logic [WORD_W-1:0] memRdata,
  input  logic [WORD_W-1:0] rfRdData,
  output logic              startHasWork,
  output logic              lastPending,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic [IDX_W-1:0]  rfRdIdx,
  output logic              rfWe,
  output logic [IDX_W-1:0]  rfWrIdx,
  output logic [WORD_W-1:0] rfWrData,
  output logic              branchEn,
  output logic [WORD_W-1:0] branchTarget
);

  localparam int BYTE_SH = $clog2(WORD_W / 8);
  localparam int CNT_W   = $clog2(LIST_W + 2);
  localparam int LSEL_W  = $clog2(LIST_W);
  localparam logic [WORD_W-1:0] STEP = WORD_W'(WORD_W / 8);

  seqOp_e              opQ;
  logic [LIST_W-1:0]   maskQ;
  logic                extraQ;
  logic [IDX_W-1:0]    baseIdxQ;
  logic [WORD_W-1:0]   addrQ;
  logic [WORD_W-1:0]   finalQ;
  logic                wbQ;

  // start-time decode
  logic                inPush, inPushPop, extraIn;
  logic [CNT_W-1:0]    startCount;
  logic [WORD_W-1:0]   span;

  always_comb begin
    inPush    = (opKind == OP_PUSH);
    inPushPop = (opKind == OP_PUSH) || (opKind == OP_POP);
    extraIn   = extraBit && inPushPop;
    startCount = CNT_W'(extraIn);
    for (int i = 0; i < LIST_W; i++) begin
      startCount = startCount + CNT_W'(regList[i]);
    end
    span = WORD_W'(startCount) << BYTE_SH;
  end

  assign startHasWork = (startCount != '0);

  // register selection from the remaining mask
  logic [IDX_W-1:0]  lowIdx, highIdx, curIdx;
  logic [LIST_W-1:0] clrMask;
  logic              extraSel;

  always_comb begin
    lowIdx  = '0;
    highIdx = '0;
    for (int i = LIST_W - 1; i >= 0; i--) begin
      if (maskQ[i]) lowIdx = IDX_W'(i);
    end
    for (int i = 0; i < LIST_W; i++) begin
      if (maskQ[i]) highIdx = IDX_W'(i);
    end
    if (opQ == OP_PUSH) begin
      curIdx = extraQ ? IDX_LR : highIdx;
    end else begin
      curIdx = (maskQ == '0 && extraQ) ? IDX_PC : lowIdx;
    end
    extraSel = (curIdx == IDX_LR) || (curIdx == IDX_PC);
    clrMask  = '0;
    if (!extraSel) clrMask[curIdx[LSEL_W-1:0]] = 1'b1;
  end

  assign lastPending = ($countones({maskQ, extraQ}) == 1);

  logic adv, isLoad;
  assign adv    = strb.xfer && memReady;
  assign isLoad = (opQ == OP_POP) || (opQ == OP_LDM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ      <= OP_PUSH;
      maskQ    <= '0;
      extraQ   <= 1'b0;
      baseIdxQ <= '0;
      addrQ    <= '0;
      finalQ   <= '0;
      wbQ      <= 1'b0;
    end else if (strb.capture) begin
      opQ      <= seqOp_e'(opKind);
      maskQ    <= regList;
      extraQ   <= extraIn;
      baseIdxQ <= inPushPop ? IDX_SP : IDX_W'(baseSel);
      addrQ    <= inPush ? baseValue - STEP : baseValue;
      finalQ   <= inPush ? baseValue - span : baseValue + span;
      wbQ      <= startHasWork && !((opKind == OP_LDM) && regList[baseSel]);
    end else if (adv) begin
      if (extraSel) extraQ <= 1'b0;
      maskQ <= maskQ & ~clrMask;
      addrQ <= (opQ == OP_PUSH) ? addrQ - STEP : addrQ + STEP;
    end
  end

  assign memReq       = strb.xfer;
  assign memWe        = strb.xfer && !isLoad;
  assign memAddr      = addrQ;
  assign memWdata     = rfRdData;
  assign rfRdIdx      = curIdx;
  assign rfWe         = (adv && isLoad && curIdx != IDX_PC) || (strb.finish && wbQ);
  assign rfWrIdx      = strb.finish ? baseIdxQ : curIdx;
  assign rfWrData     = strb.finish ? finalQ : memRdata;
  assign branchEn     = adv && isLoad && (curIdx == IDX_PC);
  assign branchTarget = memRdata;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(rfRdIdx))); // R7

  AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && opQ == OP_PUSH) |=>
      (!memReq || (rfRdIdx < $past(rfRdIdx) && memAddr == $past(memAddr) - STEP))); // R3

  AST_WALK_ASCEND: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && opQ != OP_PUSH) |=>
      (!memReq || (rfRdIdx > $past(rfRdIdx) && memAddr == $past(memAddr) + STEP))); // R4

  AST_PC_LAST: assert property (@(posedge clk) disable iff (!rstN)
    branchEn |=> !memReq); // R5

endmodule

// File: rtl/reglist_seq.sv
`timescale 1ns/1ps
module reglist_seq
  import reglist_seq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LIST_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        opKind,
  input  logic [LIST_W-1:0] regList,
  input  logic              extraBit,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [WORD_W-1:0] baseValue,
  output logic              done,
  output logic              memReq,
  output logic              memWe,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memReady,
  output logic [3:0]        rfRdIdx,
  input  logic [WORD_W-1:0] rfRdData,
  output logic              rfWe,
  output logic [3:0]        rfWrIdx,
  output logic [WORD_W-1:0] rfWrData,
  output logic              branchEn,
  output logic [WORD_W-1:0] branchTarget
);

  seqStrobe_t strb;
  logic       startHasWork;
  logic       lastPending;

  reglist_seq_ctrl i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .startHasWork (startHasWork),
    .memReady     (memReady),
    .lastPending  (lastPending),
    .strb         (strb),
    .done         (done)
  );

  reglist_seq_dpath #(
    .WORD_W (WORD_W),
    .LIST_W (LIST_W),
    .SEL_W  (SEL_W)
  ) i_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .opKind       (opKind),
    .regList      (regList),
    .extraBit     (extraBit),
    .baseSel      (baseSel),
    .baseValue    (baseValue),
    .memReady     (memReady),
    .memRdata     (memRdata),
    .rfRdData     (rfRdData),
    .startHasWork (startHasWork),
    .lastPending  (lastPending),
    .memReq       (memReq),
    .memWe        (memWe),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .rfRdIdx      (rfRdIdx),
    .rfWe         (rfWe),
    .rfWrIdx      (rfWrIdx),
    .rfWrData     (rfWrData),
    .branchEn     (branchEn),
    .branchTarget (branchTarget)
  );

endmodule

// File: tb/test_reglist_seq.sv
`timescale 1ns/1ps
module test_reglist_seq;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  opKind = '0;
  logic [7:0]  regList = '0;
  logic        extraBit = 1'b0;
  logic [2:0]  baseSel = '0;
  logic [31:0] baseValue = '0;
  logic        done, memReq, memWe, rfWe, branchEn;
  logic [31:0] memAddr, memWdata, memRdata, rfRdData, rfWrData, branchTarget;
  logic        memReady = 1'b0;
  logic [3:0]  rfRdIdx, rfWrIdx;

  logic [31:0] rfm  [16];
  logic [31:0] memm [256];

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  assign rfRdData = rfm[rfRdIdx];
  assign memRdata = memm[memAddr[9:2]];

  reglist_seq i_reglist_seq (
    .clk(clk), .rstN(rstN), .start(start), .opKind(opKind), .regList(regList),
    .extraBit(extraBit), .baseSel(baseSel), .baseValue(baseValue), .done(done),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady), .rfRdIdx(rfRdIdx), .rfRdData(rfRdData),
    .rfWe(rfWe), .rfWrIdx(rfWrIdx), .rfWrData(rfWrData), .branchEn(branchEn),
    .branchTarget(branchTarget)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference: expected transfer list, compared every cycle
  task automatic runOp(input logic [1:0] k, input logic [7:0] lst, input bit ex,
                       input logic [2:0] bsel, input logic [31:0] rdyPat,
                       input bit poke, input string req, input string wbReq);
    int          qIdx[$];
    logic [31:0] qAddr[$];
    int          bIdx;
    logic [31:0] bVal, expFinal, word;
    bit          useEx, isLd, expWb, finished;
    int          n;
    bIdx  = (k < 2) ? 13 : int'(bsel);
    bVal  = rfm[bIdx];
    useEx = ex && (k < 2);
    isLd  = (k == 1) || (k == 3);
    if (k == 0) begin
      if (useEx) qIdx.push_back(14);
      for (int i = 7; i >= 0; i--) if (lst[i]) qIdx.push_back(i);
    end else begin
      for (int i = 0; i < 8; i++) if (lst[i]) qIdx.push_back(i);
      if (useEx) qIdx.push_back(15);
    end
    n = qIdx.size();
    for (int j = 0; j < n; j++) qAddr.push_back(k == 0 ? bVal - 32'(4 * (j + 1)) : bVal + 32'(4 * j));
    expFinal = (k == 0) ? bVal - 32'(4 * n) : bVal + 32'(4 * n);
    expWb    = (n != 0) && !(k == 3 && lst[bsel]);
    finished = 1'b0;

    @(negedge clk);
    start = 1'b1; opKind = k; regList = lst; extraBit = ex; baseSel = bsel; baseValue = bVal;
    @(negedge clk);
    start = 1'b0; regList = 8'h00; baseValue = 32'hDEAD_0000;
    for (int cyc = 0; cyc < 300; cyc++) begin
      if (cyc > 0) @(negedge clk);
      memReady = rdyPat[cyc % 32];
      start = poke && (cyc == 1);
      if (poke && cyc == 1) begin opKind = 2'd3; regList = 8'hFF; baseSel = 3'd0; end
      #2;
      if (qIdx.size() == 0) begin
        chk(done === 1'b1, "R10", "done after last transfer", 32'(done), 1);
        chk(memReq === 1'b0, req, "no request at finish", 32'(memReq), 0);
        chk(rfWe === expWb, wbReq, "base writeback enable", 32'(rfWe), 32'(expWb));
        if (expWb) begin
          chk(rfWrIdx == 4'(bIdx), wbReq, "writeback index", 32'(rfWrIdx), bIdx);
          chk(rfWrData == expFinal, wbReq, "writeback value", rfWrData, expFinal);
          rfm[bIdx] = expFinal;
        end
        finished = 1'b1;
        break;
      end
      chk(done === 1'b0, "R10", "done early", 32'(done), 0);
      chk(memReq === 1'b1, "R7", "request active", 32'(memReq), 1);
      chk(memAddr == qAddr[0], req, "address", memAddr, qAddr[0]);
      chk(rfRdIdx == 4'(qIdx[0]), "R2", "register index", 32'(rfRdIdx), qIdx[0]);
      chk(memWe === !isLd, "R11", "write direction", 32'(memWe), 32'(!isLd));
      if (!isLd) chk(memWdata == rfm[qIdx[0]], "R11", "store data", memWdata, rfm[qIdx[0]]);
      if (memReady) begin
        word = memm[memAddr[9:2]];
        if (!isLd) begin
          memm[memAddr[9:2]] = memWdata;
          chk(rfWe === 1'b0, req, "no write on store", 32'(rfWe), 0);
        end else if (qIdx[0] == 15) begin
          chk(branchEn === 1'b1, "R5", "branch taken", 32'(branchEn), 1);
          chk(branchTarget == word, "R5", "branch target", branchTarget, word);
          chk(rfWe === 1'b0, "R5", "pc not in register file", 32'(rfWe), 0);
        end else begin
          chk(rfWe === 1'b1, req, "load write enable", 32'(rfWe), 1);
          chk(rfWrIdx == 4'(qIdx[0]), req, "load index", 32'(rfWrIdx), qIdx[0]);
          chk(rfWrData == word, req, "load data", rfWrData, word);
          rfm[qIdx[0]] = word;
        end
        void'(qIdx.pop_front());
        void'(qAddr.pop_front());
      end else begin
        chk(rfWe === 1'b0 && branchEn === 1'b0, "R7", "nothing written on stall",
            32'({rfWe, branchEn}), 0);
      end
    end
    start = 1'b0;
    if (!finished) chk(1'b0, req, "instruction never finished", 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) rfm[i] = 32'h1000_0000 + 32'(i * 32'h111);
    rfm[13] = 32'h0000_0200;
    for (int i = 0; i < 256; i++) memm[i] = 32'hA500_0000 + 32'(i);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(memReq === 1'b0 && done === 1'b0 && rfWe === 1'b0 && branchEn === 1'b0,
        "R1", "outputs in reset", 32'({memReq, done, rfWe, branchEn}), 0);
    rstN = 1'b1;
    @(negedge clk); #2;
    chk(memReq === 1'b0 && done === 1'b0, "R1", "idle after reset", 32'({memReq, done}), 0);

    // R3 push with link register, always ready
    runOp(2'd0, 8'h85, 1'b1, 3'd0, 32'hFFFF_FFFF, 1'b0, "R3", "R3");
    // R4 R5 pop with program counter, stalls
    runOp(2'd1, 8'h85, 1'b1, 3'd0, 32'h6DB6_DB6D, 1'b0, "R4", "R4");
    // R3 push without extra, stalls
    runOp(2'd0, 8'h5A, 1'b0, 3'd0, 32'hAAAA_AAAA, 1'b0, "R3", "R3");
    // R4 pop without extra
    runOp(2'd1, 8'h5A, 1'b0, 3'd0, 32'hFFFF_FFFF, 1'b0, "R4", "R4");
    // R6 store-multiple, extra bit ignored
    rfm[1] = 32'h0000_0100;
    runOp(2'd2, 8'h3C, 1'b1, 3'd1, 32'hCCCC_CCCC, 1'b0, "R6", "R6");
    // R6 load-multiple, base outside list
    rfm[5] = 32'h0000_0100;
    runOp(2'd3, 8'h0F, 1'b1, 3'd5, 32'hFFFF_FFFF, 1'b0, "R6", "R6");
    // R9 load-multiple, base in list
    rfm[3] = 32'h0000_0180;
    runOp(2'd3, 8'h1A, 1'b0, 3'd3, 32'h7777_7777, 1'b0, "R9", "R9");
    // R8 empty push and empty load-multiple
    runOp(2'd0, 8'h00, 1'b0, 3'd0, 32'hFFFF_FFFF, 1'b0, "R8", "R8");
    runOp(2'd3, 8'h00, 1'b1, 3'd2, 32'hFFFF_FFFF, 1'b0, "R8", "R8");
    // R3 push of link register alone
    runOp(2'd0, 8'h00, 1'b1, 3'd0, 32'h0000_0006, 1'b0, "R3", "R3");
    // R5 pop of program counter alone
    runOp(2'd1, 8'h00, 1'b1, 3'd0, 32'hFFFF_FFFF, 1'b0, "R5", "R4");
    // R10 a start pulse while busy is ignored
    runOp(2'd0, 8'hFF, 1'b0, 3'd0, 32'h9249_2492, 1'b1, "R10", "R10");
    runOp(2'd1, 8'hFF, 1'b0, 3'd0, 32'h0000_0F0F, 1'b1, "R10", "R10");

    @(negedge clk); #2;
    chk(memReq === 1'b0 && done === 1'b0, "R10", "idle after last instruction",
        32'({memReq, done}), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule